// File: doc/BRIEF.md
# Serial Flash Status Register Write Engine

This block is the device-side logic of a serial flash that accepts the status-register write command on an SPI link. It watches chip select, serial clock and serial data in. These pins are oversampled by the core clock, so SPI mode 0 and mode 3 are both accepted. Bits are taken on the rising serial-clock edge, most significant bit first. Each chip-select-framed transfer is split into an 8-bit opcode and up to two data bytes. The frame is judged only when chip select returns high.

Two enable opcodes arm a later write. The persistent enable (06h) sets the write-enable latch. The volatile enable (50h) sets an internal one-shot flag. A write (01h) followed by exactly one or exactly two data bytes then commits. A volatile-armed write updates the register on the next core clock and never raises busy. A write armed only by the latch starts a timed cycle of `WRITE_CYCLES` core clocks with busy high. At the end of that cycle the new value is applied and the latch is dropped. The 16-bit status word and the busy flag are presented in parallel at all times, so they can be polled during a write cycle.

Top module: `flash_sr_write_engine`

## Requirements
- R1: After reset, the status word is 0000h and busy is 0.
- R2: A frame of exactly 8 bits carrying 06h sets the write-enable latch, which appears as status bit 1.
- R3: A write frame (01h then byte A then byte B) under the latch alone raises busy for exactly `WRITE_CYCLES` core clocks. When busy falls, status bits 7:2 take A[7:2], bits 15:8 take B, and bit 1 (latch) is 0.
- R4: While busy is 1, status bit 0 reads 1, bit 1 stays 1, and bits 15:2 do not change.
- R5: A write frame with a single data byte A writes A[7:2] into bits 7:2 and clears bits 14 and 9. Bits 15, 13:10 and 8 keep their values.
- R6: Any frame whose total bit count is not the one its opcode needs (8 for 06h and 50h; 16 or 24 for 01h) changes nothing.
- R7: After a 50h frame of exactly 8 bits, the next committed write updates the status word within a few core clocks with busy held at 0. This path wins over the latch, and the latch is left as it was. The volatile enable is used up by that one write.
- R8: A write frame with neither enable armed changes nothing.
- R9: Every frame that ends while busy is 1 is ignored, enable opcodes included.
- R10: Status bits 1 and 0 cannot be set by write data; data bits 1:0 of byte A are discarded.
- R11: Transfers in SPI mode 0 (clock idle low) and mode 3 (clock idle high) give the same result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock; oversamples the SPI pins and times the write cycle |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| spi_cs_n | input | 1 | SPI chip select, active low |
| spi_sck | input | 1 | SPI serial clock |
| spi_mosi | input | 1 | SPI serial data into the device |
| status_q | output | 16 | Status word: bit 0 busy, bit 1 write-enable latch, bits 15:2 stored |
| busy_o | output | 1 | High during a timed persistent write cycle |

## Verification
The hardest case to reach is a frame that lands inside a running persistent cycle. To get there, the bench arms the latch, starts a two-byte write, and sends a volatile enable at once while busy is still high. It then shows that this enable left no trace: a later unarmed write is still ignored. The other delicate case has both enables armed together. This is reached by a 06h frame followed by a 50h frame. It shows that the volatile path is taken and used up, because the next write falls back to a busy cycle.

// File: rtl/flash_sr_pkg.sv
package flash_sr_pkg;

  localparam logic [7:0] OP_WR_STATUS   = 8'h01;
  localparam logic [7:0] OP_PERSIST_EN  = 8'h06;
  localparam logic [7:0] OP_VOLATILE_EN = 8'h50;

  localparam int SR_WIDTH     = 16;
  localparam int BIT_BUSY     = 0;
  localparam int BIT_LATCH    = 1;
  localparam int BIT_QUAD_EN  = 9;
  localparam int BIT_PROT_CMP = 14;

  typedef enum logic [2:0] {
    FR_NONE,
    FR_PERSIST_EN,
    FR_VOLATILE_EN,
    FR_WRITE_ONE,
    FR_WRITE_TWO
  } frame_kind_e;

  typedef enum logic [0:0] {
    ENG_IDLE,
    ENG_CYCLE
  } eng_state_e;

endpackage

// File: rtl/spi_pin_sync.sv
module spi_pin_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n_i,
  input  logic sck_i,
  input  logic mosi_i,
  output logic start_o,
  output logic end_o,
  output logic rise_o,
  output logic bit_o
);

  localparam int PIPE_W = SYNC_STAGES + 1;

  logic [PIPE_W-1:0] cs_q,   cs_n;
  logic [PIPE_W-1:0] sck_q,  sck_n;
  logic [PIPE_W-1:0] mosi_q, mosi_n;

  logic cs_now, cs_prev, sck_now, sck_prev;

  always_comb begin
    cs_n   = {cs_q[PIPE_W-2:0],   cs_n_i};
    sck_n  = {sck_q[PIPE_W-2:0],  sck_i};
    mosi_n = {mosi_q[PIPE_W-2:0], mosi_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_q   <= '1;
      sck_q  <= '0;
      mosi_q <= '0;
    end else begin
      cs_q   <= cs_n;
      sck_q  <= sck_n;
      mosi_q <= mosi_n;
    end
  end

  logic unused_mosi_tail;
  assign unused_mosi_tail = mosi_q[PIPE_W-1];

  always_comb begin
    cs_now   = cs_q[SYNC_STAGES-1];
    cs_prev  = cs_q[SYNC_STAGES];
    sck_now  = sck_q[SYNC_STAGES-1];
    sck_prev = sck_q[SYNC_STAGES];
    start_o  = !cs_now && cs_prev;
    end_o    = cs_now && !cs_prev;
    rise_o   = !cs_now && sck_now && !sck_prev;
    bit_o    = mosi_q[SYNC_STAGES-1];
  end

endmodule

// File: rtl/spi_frame_deser.sv
module spi_frame_deser
  import flash_sr_pkg::*;
#(
  parameter int CNT_W = 5
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start_i,
  input  logic        rise_i,
  input  logic        bit_i,
  input  logic        end_i,
  output logic        valid_o,
  output frame_kind_e kind_o,
  output logic [7:0]  byte_a_o,
  output logic [7:0]  byte_b_o
);

  localparam int OP_BITS  = 8;
  localparam int ONE_BITS = OP_BITS + 8;
  localparam int TWO_BITS = OP_BITS + 16;
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic [7:0]       op_q, op_n;
  logic [15:0]      dat_q, dat_n;
  logic             valid_q, valid_n;
  frame_kind_e      kind_q, kind_n;
  logic [7:0]       a_q, a_n, b_q, b_n;
  frame_kind_e      kind_now;

  always_comb begin
    kind_now = FR_NONE;
    if (op_q == OP_PERSIST_EN && cnt_q == CNT_W'(OP_BITS))
      kind_now = FR_PERSIST_EN;
    else if (op_q == OP_VOLATILE_EN && cnt_q == CNT_W'(OP_BITS))
      kind_now = FR_VOLATILE_EN;
    else if (op_q == OP_WR_STATUS && cnt_q == CNT_W'(ONE_BITS))
      kind_now = FR_WRITE_ONE;
    else if (op_q == OP_WR_STATUS && cnt_q == CNT_W'(TWO_BITS))
      kind_now = FR_WRITE_TWO;
  end

  always_comb begin
    cnt_n   = cnt_q;
    op_n    = op_q;
    dat_n   = dat_q;
    valid_n = 1'b0;
    kind_n  = kind_q;
    a_n     = a_q;
    b_n     = b_q;
    if (start_i) begin
      cnt_n = '0;
      op_n  = '0;
      dat_n = '0;
    end else if (rise_i) begin
      if (cnt_q < CNT_W'(OP_BITS)) op_n = {op_q[6:0], bit_i};
      else                         dat_n = {dat_q[14:0], bit_i};
      if (cnt_q != CNT_MAX) cnt_n = cnt_q + 1'b1;
    end
    if (end_i) begin
      valid_n = (kind_now != FR_NONE);
      kind_n  = kind_now;
      if (kind_now == FR_WRITE_ONE) begin
        a_n = dat_q[7:0];
        b_n = '0;
      end else begin
        a_n = dat_q[15:8];
        b_n = dat_q[7:0];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      op_q    <= '0;
      dat_q   <= '0;
      valid_q <= 1'b0;
      kind_q  <= FR_NONE;
      a_q     <= '0;
      b_q     <= '0;
    end else begin
      cnt_q   <= cnt_n;
      op_q    <= op_n;
      dat_q   <= dat_n;
      valid_q <= valid_n;
      kind_q  <= kind_n;
      a_q     <= a_n;
      b_q     <= b_n;
    end
  end

  assign valid_o  = valid_q;
  assign kind_o   = kind_q;
  assign byte_a_o = a_q;
  assign byte_b_o = b_q;

endmodule

// File: rtl/sr_commit_ctrl.sv
module sr_commit_ctrl
  import flash_sr_pkg::*;
#(
  parameter int WRITE_CYCLES = 200
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                valid_i,
  input  frame_kind_e         kind_i,
  input  logic [7:0]          byte_a_i,
  input  logic [7:0]          byte_b_i,
  output logic [SR_WIDTH-1:0] status_o,
  output logic                busy_o
);

  localparam int CYC_W = (WRITE_CYCLES < 2) ? 1 : $clog2(WRITE_CYCLES);
  localparam logic [CYC_W-1:0] CYC_LOAD = CYC_W'(WRITE_CYCLES - 1);

  eng_state_e              st_q, st_n;
  logic [CYC_W-1:0]        cyc_q, cyc_n;
  logic [SR_WIDTH-1:2]     sr_q, sr_n;
  logic [SR_WIDTH-1:2]     pend_q, pend_n;
  logic                    latch_q, latch_n;
  logic                    vol_q, vol_n;
  logic [SR_WIDTH-1:2]     merged;
  logic                    is_write;

  logic unused_low_bits;
  assign unused_low_bits = ^byte_a_i[1:0];

  always_comb begin
    merged = sr_q;
    if (kind_i == FR_WRITE_TWO) begin
      merged[15:8] = byte_b_i;
    end else begin
      merged[BIT_PROT_CMP] = 1'b0;
      merged[BIT_QUAD_EN]  = 1'b0;
    end
    merged[7:2] = byte_a_i[7:2];
    is_write = (kind_i == FR_WRITE_ONE) || (kind_i == FR_WRITE_TWO);
  end

  always_comb begin
    st_n    = st_q;
    cyc_n   = cyc_q;
    sr_n    = sr_q;
    pend_n  = pend_q;
    latch_n = latch_q;
    vol_n   = vol_q;
    unique case (st_q)
      ENG_IDLE: begin
        if (valid_i) begin
          if (kind_i == FR_PERSIST_EN) latch_n = 1'b1;
          if (kind_i == FR_VOLATILE_EN) vol_n = 1'b1;
          if (is_write) begin
            if (vol_q) begin
              sr_n  = merged;
              vol_n = 1'b0;
            end else if (latch_q) begin
              pend_n = merged;
              cyc_n  = CYC_LOAD;
              st_n   = ENG_CYCLE;
            end
          end
        end
      end
      ENG_CYCLE: begin
        if (cyc_q == '0) begin
          sr_n    = pend_q;
          latch_n = 1'b0;
          st_n    = ENG_IDLE;
        end else begin
          cyc_n = cyc_q - 1'b1;
        end
      end
      default: st_n = ENG_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ENG_IDLE;
      cyc_q   <= '0;
      sr_q    <= '0;
      pend_q  <= '0;
      latch_q <= 1'b0;
      vol_q   <= 1'b0;
    end else begin
      st_q    <= st_n;
      cyc_q   <= cyc_n;
      sr_q    <= sr_n;
      pend_q  <= pend_n;
      latch_q <= latch_n;
      vol_q   <= vol_n;
    end
  end

  assign busy_o   = (st_q == ENG_CYCLE);
  assign status_o = {sr_q, latch_q, busy_o};

endmodule

// File: rtl/flash_sr_write_engine.sv
module flash_sr_write_engine #(
  parameter int WRITE_CYCLES = 200,
  parameter int SYNC_STAGES  = 2,
  parameter int CNT_W        = 5
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        spi_cs_n,
  input  logic        spi_sck,
  input  logic        spi_mosi,
  output logic [15:0] status_q,
  output logic        busy_o
);

  import flash_sr_pkg::*;

  logic [1:0] rst_pipe_q;
  logic       rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_core_n = rst_pipe_q[1];

  logic        f_start, f_end, f_rise, f_bit;
  logic        fr_valid;
  frame_kind_e fr_kind;
  logic [7:0]  fr_a, fr_b;

  spi_pin_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_core_n),
    .cs_n_i  (spi_cs_n),
    .sck_i   (spi_sck),
    .mosi_i  (spi_mosi),
    .start_o (f_start),
    .end_o   (f_end),
    .rise_o  (f_rise),
    .bit_o   (f_bit)
  );

  spi_frame_deser #(.CNT_W(CNT_W)) u_deser (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .start_i  (f_start),
    .rise_i   (f_rise),
    .bit_i    (f_bit),
    .end_i    (f_end),
    .valid_o  (fr_valid),
    .kind_o   (fr_kind),
    .byte_a_o (fr_a),
    .byte_b_o (fr_b)
  );

  sr_commit_ctrl #(.WRITE_CYCLES(WRITE_CYCLES)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .valid_i  (fr_valid),
    .kind_i   (fr_kind),
    .byte_a_i (fr_a),
    .byte_b_i (fr_b),
    .status_o (status_q),
    .busy_o   (busy_o)
  );

endmodule

// File: rtl/flash_sr_write_engine_chk.sv
module flash_sr_write_engine_chk #(
  parameter int WRITE_CYCLES = 200
) (
  input logic        clk,
  input logic        rst_n,
  input logic [15:0] status_q,
  input logic        busy_o
);

  int unsigned busy_len_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      busy_len_q <= 0;
    else if (busy_o) busy_len_q <= busy_len_q + 1;
    else             busy_len_q <= 0;
  end

  AST_BUSY_SPAN: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> (busy_len_q == WRITE_CYCLES)); // R3

  AST_LATCH_DROPS_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> !status_q[1]); // R3

  AST_LATCH_HELD_IN_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> status_q[1]); // R4

  AST_FROZEN_IN_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && $past(busy_o)) |-> $stable(status_q[15:2])); // R4

  AST_NO_ENABLE_IN_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status_q[1]) |-> !busy_o); // R9

endmodule

bind flash_sr_write_engine flash_sr_write_engine_chk #(.WRITE_CYCLES(WRITE_CYCLES)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .status_q (status_q),
  .busy_o   (busy_o)
);

// File: tb/flash_sr_write_engine_tb.sv
module flash_sr_write_engine_tb;

  localparam int WCYC = 200;

  logic        clk;
  logic        rst_n;
  logic        cs_n;
  logic        sck;
  logic        mosi;
  logic [15:0] status_q;
  logic        busy_o;

  int n_cmp  = 0;
  int n_fail = 0;
  bit done   = 0;

  typedef struct {
    string       tag;
    logic [15:0] st;
    logic        busy;
  } exp_t;

  exp_t exp_q[$];

  flash_sr_write_engine #(.WRITE_CYCLES(WCYC)) u_dut (
    .clk      (clk),
    .rst_n    (rst_n),
    .spi_cs_n (cs_n),
    .spi_sck  (sck),
    .spi_mosi (mosi),
    .status_q (status_q),
    .busy_o   (busy_o)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic expect_now(input string tag, input logic [15:0] st, input logic bsy);
    exp_t e;
    e.tag = tag;
    e.st = st;
    e.busy = bsy;
    exp_q.push_back(e);
    tick(1);
  endtask

  task automatic send(input logic [31:0] bits, input int n, input bit m3);
    sck  = m3;
    cs_n = 1'b1;
    mosi = 1'b0;
    tick(4);
    cs_n = 1'b0;
    tick(4);
    for (int i = n - 1; i >= 0; i--) begin
      if (m3) sck = 1'b0;
      mosi = bits[i];
      tick(4);
      sck = 1'b1;
      tick(4);
      if (!m3) sck = 1'b0;
    end
    tick(4);
    cs_n = 1'b1;
    tick(10);
  endtask

  task automatic report;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_fail);
  endtask

  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      exp_t e;
      e = exp_q.pop_front();
      n_cmp++;
      if (status_q !== e.st || busy_o !== e.busy) begin
        n_fail++;
        $display("FAIL %s: status=%h busy=%b expected status=%h busy=%b",
                 e.tag, status_q, busy_o, e.st, e.busy);
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      report();
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    cs_n  = 1'b1;
    sck   = 1'b0;
    mosi  = 1'b0;
    tick(5);
    rst_n = 1'b1;
    tick(5);
    expect_now("R1 reset state", 16'h0000, 1'b0);

    // R6: enable opcode with 9 bits, disable-count volatile enable with 7 bits
    send({23'd0, 8'h06, 1'b0}, 9, 1'b0);
    expect_now("R6 06h with 9 bits ignored", 16'h0000, 1'b0);
    send(32'h28, 7, 1'b1);
    // R8: write with no enable armed
    send(32'h01FC, 16, 1'b0);
    expect_now("R8 unarmed write ignored", 16'h0000, 1'b0);

    send(32'h06, 8, 1'b0);
    expect_now("R2 latch set by 06h (R11 mode 0)", 16'h0002, 1'b0);

    // R3/R4: persistent two-byte write, mode 3
    send(32'h01A5FF, 24, 1'b1);
    expect_now("R4 busy cycle running (R11 mode 3)", 16'h0003, 1'b1);
    send(32'h50, 8, 1'b0);
    expect_now("R9 frame during cycle, status frozen", 16'h0003, 1'b1);
    tick(WCYC);
    expect_now("R3 R10 two-byte commit, latch cleared", 16'hFFA4, 1'b0);
    send(32'h010000, 24, 1'b0);
    expect_now("R9 volatile enable sent in cycle left no trace", 16'hFFA4, 1'b0);

    // R5: one-byte persistent write
    send(32'h06, 8, 1'b1);
    expect_now("R2 latch set again", 16'hFFA6, 1'b0);
    send(32'h013C, 16, 1'b0);
    expect_now("R4 one-byte cycle running", 16'hFFA7, 1'b1);
    tick(WCYC);
    expect_now("R5 one-byte commit clears bits 14 and 9", 16'hBD3C, 1'b0);

    // R6: bad write counts keep the latch
    send(32'h06, 8, 1'b0);
    send(32'h01ABC, 20, 1'b0);
    expect_now("R6 write with 12 data bits discarded", 16'hBD3E, 1'b0);
    send({7'd0, 8'h01, 17'd0}, 25, 1'b1);
    expect_now("R6 write with 17 data bits discarded", 16'hBD3E, 1'b0);

    // R7: volatile wins over latch, consumed by one write
    send(32'h50, 8, 1'b1);
    send(32'h011234, 24, 1'b1);
    expect_now("R7 volatile write immediate, latch kept", 16'h3412, 1'b0);
    send(32'h010000, 24, 1'b0);
    expect_now("R7 volatile enable consumed, persistent cycle", 16'h3413, 1'b1);
    tick(WCYC);
    expect_now("R3 second persistent commit", 16'h0000, 1'b0);

    send(32'h50, 8, 1'b0);
    send(32'h01FC, 16, 1'b1);
    expect_now("R7 volatile one-byte write without latch", 16'h00FC, 1'b0);
    send(32'h010000, 24, 1'b0);
    expect_now("R8 write after consumed enable ignored", 16'h00FC, 1'b0);

    tick(4);
    done = 1;
    report();
    $finish;
  end

endmodule